// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block turns a whole-range program or erase request into the byte-by-byte traffic that a serial NOR flash expects. It sits above a byte-level transaction layer that shifts one byte at a time and releases chip select after a byte marked as final. A program request supplies a start offset, a length and a byte stream. The sequencer cuts the range at page boundaries and runs each piece as its own step. An erase request is cut into whole sectors in the same way.

Each step first waits for the flash to be idle. It then sets the write-enable latch and confirms by reading it back. Next it sends the page-program or sector-erase command with a three-byte address, followed by the data bytes for a program step. Last, it polls the busy flag until the flash is ready again.

Before any traffic, the whole request is checked for size, alignment and a global lock. Each step is also checked on its own against a protected address window. The first failure ends the request. Every request ends with a one-cycle done pulse and a result code.

Top module: `flash_pe_seq`

## Requirements
- R1: No program step crosses a `PAGE_BYTES` boundary. Its length is the smaller of the bytes still to write and the room left in the current page.
- R2: Each step begins the same way. The sequencer polls status until the flash is not busy, sends write-enable 0x06 alone under chip select, then reads status again. If bit 1 (write-enable latch) of that read is 0, the request ends with result 3 (busy).
- R3: A status read is opcode 0x05 followed by one read byte, with chip select released after the read. Bit 0 is the busy flag. When `POLL_MAX` reads in a row return busy, the request ends with result 4 (timeout).
- R4: If offset plus length exceeds `FLASH_BYTES`, the request ends with result 1 (invalid) and no bus traffic. A range that ends exactly at the flash end is accepted.
- R5: A step whose range [a, a+n) overlaps the protected window [b, b+m) is refused with result 2 (denied) before any of its traffic. Overlap means max(a,b) < min(a+n, b+m). Steps before it have already completed.
- R6: Erase runs one `SECTOR_BYTES` sector per step. Each step sends 0x20 and then three address bytes, most significant first, with chip select released after the last address byte.
- R7: A program whose offset or length is not a multiple of `MIN_WRITE` ends with result 1 (invalid). So does an erase whose offset or length is not a multiple of `SECTOR_BYTES`. Neither produces bus traffic.
- R8: While `lock_all` is high, every program or erase request that passes the size and alignment checks ends with result 2 (denied) and no bus traffic.
- R9: A program step sends 0x02, then three address bytes most significant first, then the step's data bytes in stream order. Chip select is released after the last data byte, and each data byte is taken from the stream exactly once.
- R10: Each request ends with `done` high for exactly one cycle together with `result`. Result 0 means success. A request of length zero succeeds with no bus traffic.
- R11: `req_ready` is high only while the sequencer is idle. It goes low in the cycle after a request that needs bus traffic is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_offset | input | AW | Start byte offset |
| req_length | input | AW+1 | Length in bytes |
| wdat_valid | input | 1 | Program stream byte available |
| wdat_byte | input | 8 | Program stream byte |
| wdat_take | output | 1 | Stream byte consumed this cycle |
| prot_base | input | AW | Start of protected window |
| prot_size | input | AW+1 | Size of protected window (0 = none) |
| lock_all | input | 1 | Refuse all program and erase requests |
| xfer_valid | output | 1 | Byte transfer requested |
| xfer_ready | input | 1 | Byte transfer completes this cycle |
| xfer_byte | output | 8 | Byte to send |
| xfer_rd | output | 1 | 1 = read a byte instead of sending |
| xfer_last | output | 1 | Release chip select after this byte |
| xfer_rdata | input | 8 | Read byte, valid with xfer_ready |
| done | output | 1 | Request finished (one cycle) |
| result | output | 3 | 0 ok, 1 invalid, 2 denied, 3 busy, 4 timeout |

## Verification
A wrong step length or a stale address shows on the byte bus within the very next step. The command header would carry a wrong address byte, or chip select would be released on the wrong data byte, and the scoreboard catches either one at that byte. A poll counter or phase register that has gone wrong shows up as a missing or extra 0x05 pair after a program or erase command. It can also show as a result code that differs at the done pulse. A broken precheck shows as traffic that should not exist, caught by the first byte moved.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_INVALID = 3'd1,
    RES_DENIED  = 3'd2,
    RES_BUSY    = 3'd3,
    RES_TIMEOUT = 3'd4
  } fpe_res_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STEP, ST_SR_OP, ST_SR_RD, ST_WREN, ST_CMD, ST_ADDR, ST_DATA
  } fpe_state_e;

  typedef enum logic [1:0] {PH_PRE, PH_WEL, PH_POST} fpe_phase_e;

  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam int SR_BUSY_BIT = 0;
  localparam int SR_WEL_BIT  = 1;
endpackage

// File: rtl/fpe_chunk_len.sv
module fpe_chunk_len #(
  parameter int LW           = 25,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  localparam int PG_W        = $clog2(PAGE_BYTES)
) (
  input  logic [PG_W-1:0] page_off,
  input  logic [LW-1:0]   remain,
  input  logic            erase,
  output logic [LW-1:0]   step_len
);
  logic [LW-1:0] room;
  logic [LW-1:0] cap;

  always_comb begin
    room     = LW'(PAGE_BYTES) - LW'(page_off);
    cap      = erase ? LW'(SECTOR_BYTES) : room;
    step_len = (remain < cap) ? remain : cap;
  end
endmodule

// File: rtl/fpe_range_chk.sv
module fpe_range_chk #(
  parameter int AW          = 24,
  parameter int LW          = 25,
  parameter int FLASH_BYTES = 1 << 20
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] span,
  input  logic [AW-1:0] win_base,
  input  logic [LW-1:0] win_span,
  output logic          out_of_range,
  output logic          overlaps
);
  localparam int SW = AW + 2;
  logic [SW-1:0] s_lo, s_hi, w_lo, w_hi, lo, hi;

  always_comb begin
    s_lo = SW'(base);
    s_hi = SW'(base) + SW'(span);
    w_lo = SW'(win_base);
    w_hi = SW'(win_base) + SW'(win_span);
    lo   = (s_lo > w_lo) ? s_lo : w_lo;
    hi   = (s_hi < w_hi) ? s_hi : w_hi;
    overlaps     = lo < hi;
    out_of_range = s_hi > SW'(FLASH_BYTES);
  end
endmodule

// File: rtl/fpe_poll_ctr.sv
module fpe_poll_ctr #(
  parameter int POLL_MAX = 1000,
  localparam int CW      = $clog2(POLL_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + CW'(1);
  end

  assign at_limit = (count == CW'(POLL_MAX - 1));
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fpe_pkg::*;
#(
  parameter int AW           = 24,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int FLASH_BYTES  = 1 << 20,
  parameter int MIN_WRITE    = 4,
  parameter int POLL_MAX     = 1000,
  localparam int LW          = AW + 1,
  localparam int PG_W        = $clog2(PAGE_BYTES),
  localparam int CW          = $clog2(POLL_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic [AW-1:0] req_offset,
  input  logic [LW-1:0] req_length,
  input  logic          wdat_valid,
  input  logic [7:0]    wdat_byte,
  output logic          wdat_take,
  input  logic [AW-1:0] prot_base,
  input  logic [LW-1:0] prot_size,
  input  logic          lock_all,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [7:0]    xfer_byte,
  output logic          xfer_rd,
  output logic          xfer_last,
  input  logic [7:0]    xfer_rdata,
  output logic          done,
  output logic [2:0]    result
);
  fpe_state_e    state;
  fpe_phase_e    phase;
  logic          erase_q;
  logic [AW-1:0] cur_off;
  logic [LW-1:0] remain;
  logic [LW-1:0] chunk_q;
  logic [LW-1:0] dcnt;
  logic [1:0]    aidx;
  logic          done_q;
  fpe_res_e      res_q;

  logic [LW-1:0] step_len;
  logic [AW-1:0] rc_base;
  logic [LW-1:0] rc_span;
  logic          rc_oob, rc_overlap;
  logic          align_bad;
  logic          poll_clr, poll_inc, poll_limit;
  logic [CW-1:0] poll_count;
  logic [23:0]   addr24;
  logic          sr_busy, sr_wel;
  logic [5:0]    unused_sr;

  fpe_chunk_len #(.LW(LW), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_chunk (
    .page_off(cur_off[PG_W-1:0]), .remain(remain), .erase(erase_q), .step_len(step_len));

  assign rc_base = (state == ST_IDLE) ? req_offset : cur_off;
  assign rc_span = (state == ST_IDLE) ? req_length : step_len;

  fpe_range_chk #(.AW(AW), .LW(LW), .FLASH_BYTES(FLASH_BYTES)) u_range (
    .base(rc_base), .span(rc_span), .win_base(prot_base), .win_span(prot_size),
    .out_of_range(rc_oob), .overlaps(rc_overlap));

  fpe_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc),
    .count(poll_count), .at_limit(poll_limit));

  assign sr_busy   = xfer_rdata[SR_BUSY_BIT];
  assign sr_wel    = xfer_rdata[SR_WEL_BIT];
  assign unused_sr = xfer_rdata[7:2];
  assign addr24    = 24'(cur_off);

  always_comb begin
    if (req_erase) align_bad = (({1'b0, req_offset} | req_length) & LW'(SECTOR_BYTES - 1)) != '0;
    else           align_bad = (({1'b0, req_offset} | req_length) & LW'(MIN_WRITE - 1)) != '0;
  end

  assign poll_clr = (state == ST_STEP) || (state == ST_SR_RD && xfer_ready && !sr_busy);
  assign poll_inc = (state == ST_SR_RD) && xfer_ready && sr_busy && !poll_limit;

  always_comb begin
    xfer_valid = 1'b0;
    xfer_byte  = 8'h00;
    xfer_rd    = 1'b0;
    xfer_last  = 1'b0;
    unique case (state)
      ST_SR_OP: begin xfer_valid = 1'b1; xfer_byte = OP_RDSR; end
      ST_SR_RD: begin xfer_valid = 1'b1; xfer_rd = 1'b1; xfer_last = 1'b1; end
      ST_WREN:  begin xfer_valid = 1'b1; xfer_byte = OP_WREN; xfer_last = 1'b1; end
      ST_CMD:   begin xfer_valid = 1'b1; xfer_byte = erase_q ? OP_SERASE : OP_PROG; end
      ST_ADDR: begin
        xfer_valid = 1'b1;
        xfer_last  = erase_q && (aidx == 2'd0);
        case (aidx)
          2'd2:    xfer_byte = addr24[23:16];
          2'd1:    xfer_byte = addr24[15:8];
          default: xfer_byte = addr24[7:0];
        endcase
      end
      ST_DATA: begin
        xfer_valid = wdat_valid;
        xfer_byte  = wdat_byte;
        xfer_last  = (dcnt == chunk_q - LW'(1));
      end
      default: ;
    endcase
  end

  assign wdat_take = (state == ST_DATA) && xfer_valid && xfer_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= PH_PRE;
      erase_q <= 1'b0;
      cur_off <= '0;
      remain  <= '0;
      chunk_q <= '0;
      dcnt    <= '0;
      aidx    <= 2'd2;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          erase_q <= req_erase;
          cur_off <= req_offset;
          remain  <= req_length;
          if (rc_oob || align_bad) begin done_q <= 1'b1; res_q <= RES_INVALID; end
          else if (lock_all)       begin done_q <= 1'b1; res_q <= RES_DENIED; end
          else if (req_length == '0) begin done_q <= 1'b1; res_q <= RES_OK; end
          else state <= ST_STEP;
        end
        ST_STEP: begin
          if (remain == '0) begin done_q <= 1'b1; res_q <= RES_OK; state <= ST_IDLE; end
          else if (rc_oob) begin done_q <= 1'b1; res_q <= RES_INVALID; state <= ST_IDLE; end
          else if (rc_overlap) begin done_q <= 1'b1; res_q <= RES_DENIED; state <= ST_IDLE; end
          else begin chunk_q <= step_len; phase <= PH_PRE; state <= ST_SR_OP; end
        end
        ST_SR_OP: if (xfer_ready) state <= ST_SR_RD;
        ST_SR_RD: if (xfer_ready) begin
          if (sr_busy) begin
            if (poll_limit) begin done_q <= 1'b1; res_q <= RES_TIMEOUT; state <= ST_IDLE; end
            else state <= ST_SR_OP;
          end else begin
            unique case (phase)
              PH_PRE: state <= ST_WREN;
              PH_WEL: if (sr_wel) state <= ST_CMD;
                      else begin done_q <= 1'b1; res_q <= RES_BUSY; state <= ST_IDLE; end
              default: begin
                cur_off <= cur_off + AW'(chunk_q);
                remain  <= remain - chunk_q;
                state   <= ST_STEP;
              end
            endcase
          end
        end
        ST_WREN: if (xfer_ready) begin phase <= PH_WEL; state <= ST_SR_OP; end
        ST_CMD:  if (xfer_ready) begin aidx <= 2'd2; state <= ST_ADDR; end
        ST_ADDR: if (xfer_ready) begin
          aidx <= aidx - 2'd1;
          if (aidx == 2'd0) begin
            dcnt <= '0;
            if (erase_q) begin phase <= PH_POST; state <= ST_SR_OP; end
            else state <= ST_DATA;
          end
        end
        ST_DATA: if (xfer_valid && xfer_ready) begin
          dcnt <= dcnt + LW'(1);
          if (xfer_last) begin phase <= PH_POST; state <= ST_SR_OP; end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign result    = res_q;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int LW         = 25,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_MAX   = 1000,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CW        = $clog2(POLL_MAX + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            lock_all,
  input logic            done,
  input logic [2:0]      result,
  input logic            xfer_valid,
  input logic            xfer_ready,
  input logic            xfer_rd,
  input logic            wdat_take,
  input logic            in_data,
  input logic [PG_W-1:0] page_off,
  input logic [LW-1:0]   chunk_len,
  input logic [CW-1:0]   poll_count
);
  a_r1_step_in_page: assert property (@(posedge clk) disable iff (rst)
    in_data |-> (LW'(page_off) + chunk_len) <= LW'(PAGE_BYTES));

  a_r3_poll_bounded: assert property (@(posedge clk) disable iff (rst)
    poll_count < CW'(POLL_MAX));

  a_r8_lock_no_traffic: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && lock_all) |=> !xfer_valid);

  a_r9_take_on_send: assert property (@(posedge clk) disable iff (rst)
    wdat_take |-> (xfer_valid && xfer_ready && !xfer_rd));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_result_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> result <= 3'd4);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready || done));
endmodule

bind flash_pe_seq fpe_checker #(.LW(LW), .PAGE_BYTES(PAGE_BYTES), .POLL_MAX(POLL_MAX)) u_fpe_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .lock_all(lock_all),
  .done(done), .result(result), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_rd(xfer_rd), .wdat_take(wdat_take), .in_data(state == fpe_pkg::ST_DATA),
  .page_off(cur_off[PG_W-1:0]), .chunk_len(chunk_q), .poll_count(poll_count));

// File: tb/flash_pe_seq_bench.sv
`timescale 1ns/1ps
module flash_pe_seq_bench;
  localparam int AW = 24, LW = 25;
  localparam int PAGE = 256, SECT = 4096, FLASH = 65536, MINW = 4, PMAX = 6;
  localparam int RD = 256;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, req_erase = 0;
  logic [AW-1:0] req_offset = '0;
  logic [LW-1:0] req_length = '0;
  logic wdat_take;
  logic [7:0] wdat_byte;
  logic [AW-1:0] prot_base = '0;
  logic [LW-1:0] prot_size = '0;
  logic lock_all = 0;
  logic xfer_valid, xfer_rd, xfer_last, done;
  logic xfer_ready;
  logic [7:0] xfer_byte, xfer_rdata;
  logic [2:0] result;

  int vectors = 0, miscompares = 0;
  int exp_q[$];
  int dptr;
  int busy_polls = 0;
  bit wel_stuck = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  assign wdat_byte = pat(dptr);

  flash_pe_seq #(.AW(AW), .PAGE_BYTES(PAGE), .SECTOR_BYTES(SECT), .FLASH_BYTES(FLASH),
                 .MIN_WRITE(MINW), .POLL_MAX(PMAX)) u_flash_pe_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase),
    .req_offset(req_offset), .req_length(req_length), .wdat_valid(1'b1), .wdat_byte(wdat_byte),
    .wdat_take(wdat_take), .prot_base(prot_base), .prot_size(prot_size), .lock_all(lock_all),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_byte(xfer_byte), .xfer_rd(xfer_rd),
    .xfer_last(xfer_last), .xfer_rdata(xfer_rdata), .done(done), .result(result));

  // flash model behind the byte layer
  logic m_first, m_wel;
  logic [7:0] m_op;
  int m_busy;
  always @(posedge clk) begin
    if (rst) begin
      xfer_ready <= 0; xfer_rdata <= 0; m_first <= 1; m_wel <= 0; m_op <= 0; m_busy <= 0; dptr <= 0;
    end else begin
      if (wdat_take) dptr <= dptr + 1;
      if (xfer_valid && xfer_ready) begin
        if (!xfer_rd) begin
          if (m_first) m_op <= xfer_byte;
          if (m_first && xfer_byte == 8'h06 && !wel_stuck) m_wel <= 1;
        end else if (m_busy > 0) m_busy <= m_busy - 1;
        if (xfer_last && !m_first && (m_op == 8'h02 || m_op == 8'h20)) begin
          m_busy <= busy_polls; m_wel <= 0;
        end
        m_first <= xfer_last;
        xfer_ready <= 0;
      end else if (xfer_valid) begin
        xfer_ready <= 1;
        xfer_rdata <= {6'b0, m_wel, m_busy != 0};
      end else xfer_ready <= 0;
    end
  end

  // monitor: compare each moved byte against the scoreboard
  always @(negedge clk) begin
    if (!rst && xfer_valid && xfer_ready) begin
      int got;
      got = xfer_rd ? RD : int'(xfer_byte);
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R4/R8 unexpected bus byte actual=%0h expected=none", got);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (got != e) begin
          miscompares++;
          $display("FAIL R9 bus byte actual=%0h expected=%0h", got, e);
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_sr();
    exp_q.push_back(8'h05); exp_q.push_back(RD);
  endtask

  function automatic bit ovl(int a, int n);
    int lo, hi;
    lo = (a > int'(prot_base)) ? a : int'(prot_base);
    hi = ((a + n) < int'(prot_base) + int'(prot_size)) ? a + n : int'(prot_base) + int'(prot_size);
    return lo < hi;
  endfunction

  task automatic run_op(string req, bit er, int off, int len, int bp, bit ws, int expc);
    bit pre_fail;
    int di, o, r, ch, waitc;
    busy_polls = bp; wel_stuck = ws;
    di = dptr;
    pre_fail = (off + len > FLASH) || (((off | len) & (er ? SECT - 1 : MINW - 1)) != 0)
               || lock_all || (len == 0);
    if (!pre_fail) begin
      o = off; r = len;
      while (r > 0) begin
        ch = er ? SECT : ((r < PAGE - (o % PAGE)) ? r : PAGE - (o % PAGE));
        if (ovl(o, ch)) break;
        push_sr(); exp_q.push_back(8'h06); push_sr();
        if (ws) break;
        exp_q.push_back(er ? 8'h20 : 8'h02);
        exp_q.push_back((o >> 16) & 255); exp_q.push_back((o >> 8) & 255); exp_q.push_back(o & 255);
        if (!er) for (int i = 0; i < ch; i++) exp_q.push_back(int'(pat(di++)));
        if (bp >= PMAX) begin
          for (int k = 0; k < PMAX; k++) push_sr();
          break;
        end
        for (int k = 0; k <= bp; k++) push_sr();
        o += ch; r -= ch;
      end
    end
    req_erase = er; req_offset = AW'(off); req_length = LW'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (!done) chk(!req_ready, {req, " R11 ready low while busy"}, req_ready, 0);
    waitc = 0;
    while (!done && waitc < 50000) begin @(negedge clk); waitc++; end
    chk(done, {req, " R10 done seen"}, done, 1);
    chk(result == 3'(expc), {req, " result"}, result, expc);
    chk(exp_q.size() == 0, {req, " R9 all expected bytes seen"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(!done, {req, " R10 done one cycle"}, done, 0);
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R11 reset ready", req_ready, 1);
    chk(done == 0, "R10 reset done", done, 0);
    chk(xfer_valid == 0, "R9 reset bus idle", xfer_valid, 0);

    run_op("R10 zero length", 0, 'h40, 0, 0, 0, 0);
    run_op("R9 short program", 0, 'h10, 8, 2, 0, 0);
    run_op("R1 page split 8+16", 0, 'hF8, 24, 1, 0, 0);
    run_op("R1 page split 4+256+4", 0, 'h1FC, 264, 0, 0, 0);
    run_op("R6 two-sector erase", 1, 'h2000, 'h2000, 3, 0, 0);
    run_op("R4 past flash end", 0, FLASH - 4, 8, 0, 0, 1);
    run_op("R4 ends at flash end", 0, FLASH - 4, 4, 0, 0, 0);
    run_op("R7 misaligned program", 0, 'h102, 4, 0, 0, 1);
    run_op("R7 misaligned erase", 1, 'h100, 'h1000, 0, 0, 1);
    lock_all = 1;
    run_op("R8 locked program", 0, 0, 4, 0, 0, 2);
    run_op("R8 locked erase", 1, 0, 'h1000, 0, 0, 2);
    lock_all = 0;
    prot_base = AW'('h3000); prot_size = LW'('h100);
    run_op("R5 erase hits window on 2nd sector", 1, 'h2000, 'h2000, 0, 0, 2);
    run_op("R5 program ends at window", 0, 'h2FF0, 16, 0, 0, 0);
    run_op("R5 program overlaps window", 0, 'h30FC, 8, 0, 0, 2);
    run_op("R5 program after window", 0, 'h3100, 4, 0, 0, 0);
    prot_size = '0;
    run_op("R2 latch not set", 0, 0, 4, 0, 1, 3);
    run_op("R3 just under poll limit", 0, 0, 4, PMAX - 1, 0, 0);
    run_op("R3 poll limit reached", 0, 'h20, 4, PMAX, 0, 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule